// File: doc/BRIEF.md
# Command Effects Log Generator

This block builds, in hardware, a log that lists every command opcode the device supports. Each opcode comes with a mask of side effects. After an initialisation pulse it walks the whole opcode space. The command set is the outer loop and the command within the set is the inner loop. For each supported opcode it stores one 4-byte record in a word RAM. A supported opcode is one found in a fixed lookup function.

Once the log is built the block serves two kinds of request, one at a time. A size request returns a fixed 28-byte descriptor, which carries the log identifier and the log size in bytes. A read request names a byte offset, a byte length and a 128-bit identifier. The block checks the range against the payload buffer size and compares the identifier with the fixed one. It then streams the selected bytes one per cycle. Every request ends with a single response cycle that carries a return code and the output length.

Top module: `effect_log_gen`

## Requirements
- R1: After reset, init_done_o, overflow_o, ready_o, byte_valid_o and resp_valid_o are all low, and no request is served until a scan has finished.
- R2: The scan visits opcodes in ascending order, command set outer and command inner, and writes a record only for supported opcodes. Each record is 4 bytes: the command, then the set (a 16-bit opcode, set times 256 plus command, little-endian), then the 16-bit effect mask, little-endian. The supported opcodes (set, command, effect) are (1,0,0), (1,1,0x10), (1,2,0), (1,3,0x02), (2,0,0), (3,0,0), (3,1,0x08), (4,0,0), (4,1,0), (5,0,0) and (6,0,0).
- R3: Effect mask bit 1 marks an immediate configuration change, bit 3 an immediate policy change and bit 4 an immediate log change.
- R4: A size request (req_kind_i = 0) streams 28 bytes and then responds with code 0 and length 28. Bytes 0..1 hold the entry count 1, little-endian. Bytes 2..7 are zero. Bytes 8..23 hold the identifier, least significant byte first. Bytes 24..27 hold the log size (4 times the record count), little-endian.
- R5: A read request (req_kind_i = 1) whose offset plus length exceeds PAYLOAD_BYTES streams nothing and responds with code 0x2 and length 0. This check takes priority over the identifier check. A sum exactly equal to PAYLOAD_BYTES is accepted.
- R6: A read request in range whose identifier differs from LOG_ID streams nothing and responds with code 0x3 and length 0.
- R7: A valid read streams length bytes, one per cycle, starting at the given offset. The first byte appears in the cycle after acceptance, and the final byte is flagged with byte_last_o. The response follows in the next cycle with code 0 and length equal to the requested length. Bytes past the end of the log read as zero.
- R8: A valid read of length 0 streams nothing and responds in the cycle after acceptance with code 0 and length 0.
- R9: If more opcodes are supported than DEPTH records, the scan stops once the RAM is full, raises overflow_o and finishes with exactly DEPTH records.
- R10: A request raised while ready_o is low, whether before or during the scan, is ignored and produces no bytes and no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_start_i | input | 1 | Starts a scan of the opcode space |
| init_done_o | output | 1 | Scan finished, log valid |
| overflow_o | output | 1 | Scan ran out of log RAM |
| req_valid_i | input | 1 | Request strobe, taken when ready_o is high |
| req_kind_i | input | 1 | 0 size request, 1 read request |
| req_off_i | input | 16 | Read byte offset |
| req_len_i | input | 16 | Read byte length |
| req_id_i | input | 128 | Read log identifier |
| ready_o | output | 1 | Log built and no request in flight |
| byte_valid_o | output | 1 | Output byte valid |
| byte_data_o | output | 8 | Output byte |
| byte_last_o | output | 1 | Final byte of the stream |
| resp_valid_o | output | 1 | Response cycle |
| resp_code_o | output | 8 | Return code |
| resp_len_o | output | 16 | Output length in bytes |

## Verification
The bench shrinks the opcode space to 3 set bits and 4 command bits, so a full scan takes 128 cycles and still covers all eleven supported opcodes. It sets PAYLOAD_BYTES to 64, which puts the range limit just past the 44-byte log. This lets one read reach zero bytes beyond the log, and other reads land exactly on the limit or one byte over it. A second instance with DEPTH 8 runs out of room on the ninth supported opcode, which makes the overflow stop and the truncated size visible.

// File: rtl/effect_log_pkg.sv
package effect_log_pkg;

  localparam logic [15:0] EFF_CFG = 16'h0002;
  localparam logic [15:0] EFF_POL = 16'h0008;
  localparam logic [15:0] EFF_LOG = 16'h0010;

  localparam logic [7:0] RC_OK        = 8'h00;
  localparam logic [7:0] RC_BAD_INPUT = 8'h02;
  localparam logic [7:0] RC_UNSUP     = 8'h03;

  localparam logic [15:0] SIZE_DESC_BYTES = 16'd28;

  typedef struct packed {
    logic        sup;
    logic [15:0] effect;
  } op_info_t;

  function automatic op_info_t op_lookup(input logic [7:0] set_v, input logic [7:0] cmd_v);
    op_info_t r;
    r = '0;
    case ({set_v, cmd_v})
      16'h0100: r = '{1'b1, 16'h0000};
      16'h0101: r = '{1'b1, EFF_LOG};
      16'h0102: r = '{1'b1, 16'h0000};
      16'h0103: r = '{1'b1, EFF_CFG};
      16'h0200: r = '{1'b1, 16'h0000};
      16'h0300: r = '{1'b1, 16'h0000};
      16'h0301: r = '{1'b1, EFF_POL};
      16'h0400: r = '{1'b1, 16'h0000};
      16'h0401: r = '{1'b1, 16'h0000};
      16'h0500: r = '{1'b1, 16'h0000};
      16'h0600: r = '{1'b1, 16'h0000};
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/effect_log_ram.sv
module effect_log_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [31:0]   wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [31:0]   rdata_o
);

  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/effect_log_scan.sv
module effect_log_scan
  import effect_log_pkg::*;
#(
  parameter int SET_W = 8,
  parameter int CMD_W = 8,
  parameter int DEPTH = 64,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [31:0]      wdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             overflow_o
);

  localparam int              OP_W    = SET_W + CMD_W;
  localparam logic [OP_W-1:0] OP_MAX  = '1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  typedef enum logic [1:0] {SC_IDLE, SC_RUN, SC_DONE} sc_state_e;

  sc_state_e        state_q;
  logic [OP_W-1:0]  op_q;
  logic [CNT_W-1:0] count_q;
  logic             done_q, ovf_q;
  logic [7:0]       set8, cmd8;
  op_info_t         info;
  logic             full;

  always_comb begin
    set8 = '0;
    cmd8 = '0;
    set8[SET_W-1:0] = op_q[OP_W-1:CMD_W];
    cmd8[CMD_W-1:0] = op_q[CMD_W-1:0];
  end

  assign info = op_lookup(set8, cmd8);
  assign full = (count_q == DEPTH_C);

  assign we_o    = (state_q == SC_RUN) && info.sup && !full;
  assign waddr_o = count_q[AW-1:0];
  assign wdata_o = {info.effect, set8, cmd8};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SC_IDLE;
      op_q    <= '0;
      count_q <= '0;
      done_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      case (state_q)
        SC_RUN: begin
          if (info.sup && full) begin
            ovf_q   <= 1'b1;
            done_q  <= 1'b1;
            state_q <= SC_DONE;
          end else begin
            if (info.sup) count_q <= count_q + 1'b1;
            if (op_q == OP_MAX) begin
              done_q  <= 1'b1;
              state_q <= SC_DONE;
            end else begin
              op_q <= op_q + 1'b1;
            end
          end
        end
        default: begin
          if (start_i) begin
            state_q <= SC_RUN;
            op_q    <= '0;
            count_q <= '0;
            done_q  <= 1'b0;
            ovf_q   <= 1'b0;
          end
        end
      endcase
    end
  end

  assign count_o    = count_q;
  assign busy_o     = (state_q == SC_RUN);
  assign done_o     = done_q;
  assign overflow_o = ovf_q;

  // R9
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= DEPTH_C);

  // R9
  ovf_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_q |-> (count_q == DEPTH_C) && done_q);

  // R2
  scan_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SC_RUN) && (op_q != OP_MAX) && !(info.sup && full) |=> op_q == $past(op_q) + 1'b1);

endmodule

// File: rtl/effect_log_serve.sv
module effect_log_serve
  import effect_log_pkg::*;
#(
  parameter int           DEPTH         = 64,
  parameter int           AW            = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int           CNT_W         = $clog2(DEPTH + 1),
  parameter int           PAYLOAD_BYTES = 512,
  parameter logic [127:0] LOG_ID        = 128'h0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             log_ready_i,
  input  logic [CNT_W-1:0] count_i,
  output logic [AW-1:0]    raddr_o,
  input  logic [31:0]      rdata_i,
  input  logic             req_valid_i,
  input  logic             req_kind_i,
  input  logic [15:0]      req_off_i,
  input  logic [15:0]      req_len_i,
  input  logic [127:0]     req_id_i,
  output logic             ready_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic             byte_last_o,
  output logic             resp_valid_o,
  output logic [7:0]       resp_code_o,
  output logic [15:0]      resp_len_o
);

  localparam logic [16:0] LIMIT = 17'(PAYLOAD_BYTES);

  typedef enum logic [1:0] {SV_IDLE, SV_STREAM, SV_RESP} sv_state_e;

  sv_state_e   state_q;
  logic        src_size_q;
  logic [15:0] pos_q, left_q, rlen_q;
  logic [7:0]  code_q;

  logic        accept, bad_range, id_miss;
  logic [16:0] end_sum;
  logic [31:0] log_bytes;
  logic [15:0] word_idx, count16;
  logic [7:0]  size_byte, log_byte;
  int          p;

  assign ready_o   = log_ready_i && (state_q == SV_IDLE);
  assign accept    = req_valid_i && ready_o;
  assign end_sum   = {1'b0, req_off_i} + {1'b0, req_len_i};
  assign bad_range = end_sum > LIMIT;
  assign id_miss   = req_id_i != LOG_ID;
  assign log_bytes = 32'(count_i) << 2;

  always_comb begin
    p = int'(pos_q);
    size_byte = '0;
    if (p == 0) size_byte = 8'd1;
    else if (p >= 8 && p < 24) size_byte = LOG_ID[8*(p-8) +: 8];
    else if (p >= 24 && p < 28) size_byte = log_bytes[8*(p-24) +: 8];
  end

  assign word_idx = {2'b00, pos_q[15:2]};
  assign count16  = 16'(count_i);
  assign raddr_o  = word_idx[AW-1:0];
  assign log_byte = (word_idx < count16) ? rdata_i[8*pos_q[1:0] +: 8] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SV_IDLE;
      src_size_q <= 1'b0;
      pos_q      <= '0;
      left_q     <= '0;
      rlen_q     <= '0;
      code_q     <= RC_OK;
    end else begin
      case (state_q)
        SV_IDLE: begin
          if (accept) begin
            if (!req_kind_i) begin
              src_size_q <= 1'b1;
              pos_q      <= '0;
              left_q     <= SIZE_DESC_BYTES;
              rlen_q     <= SIZE_DESC_BYTES;
              code_q     <= RC_OK;
              state_q    <= SV_STREAM;
            end else if (bad_range) begin
              code_q  <= RC_BAD_INPUT;
              rlen_q  <= '0;
              state_q <= SV_RESP;
            end else if (id_miss) begin
              code_q  <= RC_UNSUP;
              rlen_q  <= '0;
              state_q <= SV_RESP;
            end else if (req_len_i == '0) begin
              code_q  <= RC_OK;
              rlen_q  <= '0;
              state_q <= SV_RESP;
            end else begin
              src_size_q <= 1'b0;
              pos_q      <= req_off_i;
              left_q     <= req_len_i;
              rlen_q     <= req_len_i;
              code_q     <= RC_OK;
              state_q    <= SV_STREAM;
            end
          end
        end
        SV_STREAM: begin
          pos_q  <= pos_q + 1'b1;
          left_q <= left_q - 1'b1;
          if (left_q == 16'd1) state_q <= SV_RESP;
        end
        default: state_q <= SV_IDLE;
      endcase
    end
  end

  assign byte_valid_o = (state_q == SV_STREAM);
  assign byte_data_o  = src_size_q ? size_byte : log_byte;
  assign byte_last_o  = (state_q == SV_STREAM) && (left_q == 16'd1);
  assign resp_valid_o = (state_q == SV_RESP);
  assign resp_code_o  = code_q;
  assign resp_len_o   = rlen_q;

  // R5
  bad_input_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o && (resp_code_o == RC_BAD_INPUT) |-> resp_len_o == '0);

  // R7
  last_then_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_last_o |=> resp_valid_o && (resp_code_o == RC_OK));

  // R7
  byte_resp_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_o && resp_valid_o));

  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_valid_o || resp_valid_o) |-> !ready_o);

endmodule

// File: rtl/effect_log_gen.sv
module effect_log_gen #(
  parameter int           SET_W         = 8,
  parameter int           CMD_W         = 8,
  parameter int           DEPTH         = 64,
  parameter int           PAYLOAD_BYTES = 512,
  parameter logic [127:0] LOG_ID        = 128'h6e21_d4f0_93ab_4c57_a812_3be9_70c4_1f5d
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_start_i,
  output logic         init_done_o,
  output logic         overflow_o,
  input  logic         req_valid_i,
  input  logic         req_kind_i,
  input  logic [15:0]  req_off_i,
  input  logic [15:0]  req_len_i,
  input  logic [127:0] req_id_i,
  output logic         ready_o,
  output logic         byte_valid_o,
  output logic [7:0]   byte_data_o,
  output logic         byte_last_o,
  output logic         resp_valid_o,
  output logic [7:0]   resp_code_o,
  output logic [15:0]  resp_len_o
);

  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             we, scan_busy;
  logic [AW-1:0]    waddr, raddr;
  logic [31:0]      wdata, rdata;
  logic [CNT_W-1:0] count;

  effect_log_scan #(
    .SET_W(SET_W), .CMD_W(CMD_W), .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W)
  ) u_scan (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (init_start_i),
    .we_o       (we),
    .waddr_o    (waddr),
    .wdata_o    (wdata),
    .count_o    (count),
    .busy_o     (scan_busy),
    .done_o     (init_done_o),
    .overflow_o (overflow_o)
  );

  effect_log_ram #(.DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (raddr),
    .rdata_o (rdata)
  );

  effect_log_serve #(
    .DEPTH(DEPTH), .AW(AW), .CNT_W(CNT_W),
    .PAYLOAD_BYTES(PAYLOAD_BYTES), .LOG_ID(LOG_ID)
  ) u_serve (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .log_ready_i  (init_done_o),
    .count_i      (count),
    .raddr_o      (raddr),
    .rdata_i      (rdata),
    .req_valid_i  (req_valid_i),
    .req_kind_i   (req_kind_i),
    .req_off_i    (req_off_i),
    .req_len_i    (req_len_i),
    .req_id_i     (req_id_i),
    .ready_o      (ready_o),
    .byte_valid_o (byte_valid_o),
    .byte_data_o  (byte_data_o),
    .byte_last_o  (byte_last_o),
    .resp_valid_o (resp_valid_o),
    .resp_code_o  (resp_code_o),
    .resp_len_o   (resp_len_o)
  );

  // R10
  scan_blocks_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_busy |-> !ready_o && !init_done_o);

endmodule

// File: tb/effect_log_gen_test.sv
module effect_log_gen_test;

  localparam int           SW     = 3;
  localparam int           CW     = 4;
  localparam int           DEP_A  = 16;
  localparam int           DEP_B  = 8;
  localparam int           PB     = 64;
  localparam logic [127:0] LID    = 128'h0f1e_2d3c_4b5a_6978_8796_a5b4_c3d2_e1f0;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic         init_start = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_kind = 1'b0;
  logic [15:0]  req_off = '0;
  logic [15:0]  req_len = '0;
  logic [127:0] req_id = '0;

  logic        done_a, ovf_a, rdy_a, bv_a, bl_a, rv_a;
  logic [7:0]  bd_a, rc_a;
  logic [15:0] rl_a;
  logic        done_b, ovf_b, rdy_b, bv_b, bl_b, rv_b;
  logic [7:0]  bd_b, rc_b;
  logic [15:0] rl_b;

  effect_log_gen #(.SET_W(SW), .CMD_W(CW), .DEPTH(DEP_A), .PAYLOAD_BYTES(PB), .LOG_ID(LID)) uut (
    .clk_i(clk), .rst_ni(rst_n), .init_start_i(init_start), .init_done_o(done_a),
    .overflow_o(ovf_a), .req_valid_i(req_valid), .req_kind_i(req_kind), .req_off_i(req_off),
    .req_len_i(req_len), .req_id_i(req_id), .ready_o(rdy_a), .byte_valid_o(bv_a),
    .byte_data_o(bd_a), .byte_last_o(bl_a), .resp_valid_o(rv_a), .resp_code_o(rc_a),
    .resp_len_o(rl_a));

  effect_log_gen #(.SET_W(SW), .CMD_W(CW), .DEPTH(DEP_B), .PAYLOAD_BYTES(PB), .LOG_ID(LID)) uut_small (
    .clk_i(clk), .rst_ni(rst_n), .init_start_i(init_start), .init_done_o(done_b),
    .overflow_o(ovf_b), .req_valid_i(req_valid), .req_kind_i(req_kind), .req_off_i(req_off),
    .req_len_i(req_len), .req_id_i(req_id), .ready_o(rdy_b), .byte_valid_o(bv_b),
    .byte_data_o(bd_b), .byte_last_o(bl_b), .resp_valid_o(rv_b), .resp_code_o(rc_b),
    .resp_len_o(rl_b));

  logic sel = 1'b0;
  logic        o_rdy, o_bv, o_bl, o_rv;
  logic [7:0]  o_bd, o_rc;
  logic [15:0] o_rl;
  always_comb begin
    o_rdy = sel ? rdy_b : rdy_a;
    o_bv  = sel ? bv_b  : bv_a;
    o_bl  = sel ? bl_b  : bl_a;
    o_rv  = sel ? rv_b  : rv_a;
    o_bd  = sel ? bd_b  : bd_a;
    o_rc  = sel ? rc_b  : rc_a;
    o_rl  = sel ? rl_b  : rl_a;
  end

  int n_run = 0;
  int n_fail = 0;
  byte unsigned log_a[$];
  byte unsigned log_b[$];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit tb_sup(input int s, input int c, output int eff);
    int ts[11] = '{1, 1, 1, 1, 2, 3, 3, 4, 4, 5, 6};
    int tc[11] = '{0, 1, 2, 3, 0, 0, 1, 0, 1, 0, 0};
    int te[11] = '{0, 16, 0, 2, 0, 0, 8, 0, 0, 0, 0};
    eff = 0;
    for (int k = 0; k < 11; k++)
      if (ts[k] == s && tc[k] == c) begin
        eff = te[k];
        return 1'b1;
      end
    return 1'b0;
  endfunction

  task automatic idle_check(input string req);
    chk(o_bv == 1'b0, req, o_bv, 0);
    chk(o_rv == 1'b0, req, o_rv, 0);
  endtask

  // Issues one request and compares the outputs cycle by cycle with the model.
  task automatic run_req(input logic s, input logic kind, input int off, input int len,
                         input logic [127:0] id, input string req);
    byte unsigned exp_q[$];
    int code, rlen, nb, sz;
    nb = s ? log_b.size() : log_a.size();
    sz = nb;
    if (!kind) begin
      for (int i = 0; i < 28; i++) begin
        if (i == 0) exp_q.push_back(8'd1);
        else if (i >= 8 && i < 24) exp_q.push_back(LID[8*(i-8) +: 8]);
        else if (i >= 24) exp_q.push_back(8'((sz >> (8*(i-24))) & 255));
        else exp_q.push_back(8'd0);
      end
      code = 0; rlen = 28;
    end else if (off + len > PB) begin
      code = 2; rlen = 0;
    end else if (id != LID) begin
      code = 3; rlen = 0;
    end else begin
      code = 0; rlen = len;
      for (int i = off; i < off + len; i++)
        exp_q.push_back((i < nb) ? (s ? log_b[i] : log_a[i]) : 8'd0);
    end
    sel = s;
    @(negedge clk);
    req_valid = 1'b1; req_kind = kind; req_off = 16'(off); req_len = 16'(len); req_id = id;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < exp_q.size(); i++) begin
      chk(o_bv == 1'b1, req, o_bv, 1);
      chk(o_bd == exp_q[i], req, o_bd, exp_q[i]);
      chk(o_bl == (i == exp_q.size() - 1), req, o_bl, (i == exp_q.size() - 1));
      chk(o_rv == 1'b0, req, o_rv, 0);
      @(negedge clk);
    end
    chk(o_rv == 1'b1, req, o_rv, 1);
    chk(o_bv == 1'b0, req, o_bv, 0);
    chk(o_rc == 8'(code), req, o_rc, code);
    chk(o_rl == 16'(rlen), req, o_rl, rlen);
    @(negedge clk);
    idle_check(req);
    chk(o_rdy == 1'b1, req, o_rdy, 1);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    int eff, waited;
    for (int s = 0; s < (1 << SW); s++)
      for (int c = 0; c < (1 << CW); c++)
        if (tb_sup(s, c, eff)) begin
          byte unsigned rec[4];
          rec = '{8'(c), 8'(s), 8'(eff & 255), 8'(eff >> 8)};
          for (int k = 0; k < 4; k++) begin
            log_a.push_back(rec[k]);
            if (log_b.size() < 4 * DEP_B) log_b.push_back(rec[k]);
          end
        end

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done_a == 1'b0, "R1", done_a, 0);
    chk(ovf_a == 1'b0, "R1", ovf_a, 0);
    chk(rdy_a == 1'b0, "R1", rdy_a, 0);
    idle_check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a == 1'b0, "R1", rdy_a, 0);

    // R10 request before any scan
    req_valid = 1'b1; req_kind = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    idle_check("R10");
    @(negedge clk);
    idle_check("R10");

    init_start = 1'b1;
    @(negedge clk);
    init_start = 1'b0;
    repeat (5) @(negedge clk);
    // R10 request during scan
    req_valid = 1'b1; req_kind = 1'b1; req_off = 0; req_len = 4; req_id = LID;
    @(negedge clk);
    req_valid = 1'b0;
    idle_check("R10");
    chk(rdy_a == 1'b0, "R10", rdy_a, 0);
    @(negedge clk);
    idle_check("R10");

    waited = 0;
    while (!(done_a && done_b) && waited < 1000) begin
      @(negedge clk);
      waited++;
    end
    chk(done_a == 1'b1, "R2", done_a, 1);
    chk(ovf_a == 1'b0, "R9", ovf_a, 0);
    chk(ovf_b == 1'b1, "R9", ovf_b, 1);
    chk(rdy_a == 1'b1, "R10", rdy_a, 1);

    run_req(1'b0, 1'b0, 0, 0, '0, "R4");
    run_req(1'b0, 1'b1, 0, 44, LID, "R2");
    run_req(1'b0, 1'b1, 4, 4, LID, "R3");
    run_req(1'b0, 1'b1, 12, 4, LID, "R3");
    run_req(1'b0, 1'b1, 6, 9, LID, "R7");
    run_req(1'b0, 1'b1, 40, 20, LID, "R7");
    run_req(1'b0, 1'b1, 0, 64, LID, "R5");
    run_req(1'b0, 1'b1, 60, 5, LID, "R5");
    run_req(1'b0, 1'b1, 60, 5, ~LID, "R5");
    run_req(1'b0, 1'b1, 0, 8, LID ^ 128'h1, "R6");
    run_req(1'b0, 1'b1, 10, 0, LID, "R8");
    run_req(1'b1, 1'b0, 0, 0, '0, "R9");
    run_req(1'b1, 1'b1, 0, 40, LID, "R9");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule